// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block gathers seven interrupt sources into a flag register and masks the flags with an enable register. It drives a single active-high interrupt request to a processor. Sources deliver one-cycle set pulses. Separate one-cycle clear pulses let neighbouring logic drop a flag as a side effect of some other register access.

A processor reaches the two registers through a small byte-wide port with a 4-bit address. Writing the flag register acknowledges flags. The enable register is both set and cleared through one address, and bit 7 of the written byte picks the direction. The request output is registered, and a one-cycle strobe marks every change of it so that a host can react to edges rather than levels.

Top module: `irq_flag_ctrl`

## Requirements
- R1: Source input bit i (0..6) of `src_set` sets flag bit i. The fixed meaning of the bits is: 0 = second handshake line of port A, 1 = first handshake line of port A, 2 = shift register done, 3 = second handshake line of port B, 4 = first handshake line of port B, 5 = second timer, 6 = first timer.
- R2: One cycle after the flags are updated, `irq_req` equals the OR of bits 6..0 of (flags AND enables). It stays low when no enabled flag is set.
- R3: A write of byte D to the flag address (4'hD) clears every flag whose bit in D[6:0] is 1 and leaves the other flags unchanged.
- R4: A write of byte D to the enable address (4'hE) with D[7]=1 sets the enable bits marked 1 in D[6:0]. With D[7]=0 it clears those bits. Unmarked enable bits keep their value.
- R5: Reading the flag address returns the flags in bits 6..0 and the current `irq_req` in bit 7.
- R6: Reading the enable address returns the enable bits in bits 6..0 with bit 7 always 1.
- R7: While `rst_n` is low at a clock edge, all flags, all enables, `irq_req` and `irq_changed` become 0. This applies both at start-up and in mid-run.
- R8: When a set pulse and a clear for the same flag arrive in the same cycle, the flag ends up set. This holds whether the clear comes from `src_clr` or from a flag-register write.
- R9: A pulse on `src_clr` bit i clears flag i only. The other flags are unchanged.
- R10: `irq_changed` is high for exactly the one cycle in which `irq_req` has just taken a new value, on both rising and falling changes.
- R11: Reads of any other address return 8'h00. Writes to any other address change neither flags nor enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_set | input | 7 | One-cycle set pulses, one per source |
| src_clr | input | 7 | One-cycle clear pulses from side-effect logic |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on `bus_addr` |
| irq_req | output | 1 | Registered interrupt request |
| irq_changed | output | 1 | One-cycle strobe on each change of `irq_req` |

## Verification
The bench builds the block with its default parameters: seven sources, an 8-bit data path and the status bit in bit 7. With these values, every source position, both directions of an enable write and the request bit sharing a byte with the flags can all be reached. It walks each source alone and checks masking with both overlapping and disjoint enable sets. It also drives the two set-versus-clear collisions, and checks the request strobe on a rise and on a fall against a cycle-counted schedule.

// File: rtl/irq_ctl_pkg.sv
// Shared parameters and helpers for the interrupt flag and enable controller.
// Assumes the request bit occupies the top bit of the data byte.
package irq_ctl_pkg;

    localparam int unsigned SRC_COUNT   = 7;
    localparam int unsigned BUS_DATA_W  = 8;
    localparam int unsigned BUS_ADDR_W  = 4;
    localparam logic [BUS_ADDR_W-1:0] ADDR_FLAGS  = 4'hD;
    localparam logic [BUS_ADDR_W-1:0] ADDR_ENABLE = 4'hE;

    // Direction chosen by the top bit of an enable write.
    typedef enum logic {
        EN_CLEAR = 1'b0,
        EN_SET   = 1'b1
    } en_dir_e;

endpackage

// File: rtl/irq_flag_bit.sv
// One interrupt flag cell.
// The set input wins over both clear inputs in the same cycle.
// Assumes all inputs are synchronous one-cycle pulses.
module irq_flag_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic side_clr_i,
    input  logic bus_clr_i,
    output logic flag_o
);

    // Hold the flag: set has priority, then either clear source.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (side_clr_i || bus_clr_i)
            flag_o <= 1'b0;
    end

endmodule

// File: rtl/irq_flag_bank.sv
// Bank of interrupt flags, one cell per source.
// Decodes processor writes that acknowledge flags.
// Assumes the write strobe lasts one cycle per access.
module irq_flag_bank #(
    parameter int unsigned NUM_SRC   = 7,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 4'hD
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] side_clr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [NUM_SRC-1:0] flags_o
);

    logic               hit;
    logic [NUM_SRC-1:0] bus_clr;

    // Form the per-bit acknowledge mask for a flag-register write.
    always_comb begin
        hit     = wr_i && (addr_i == FLAG_ADDR);
        bus_clr = hit ? wdata_i[NUM_SRC-1:0] : '0;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
        irq_flag_bit u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_i      (set_i[i]),
            .side_clr_i (side_clr_i[i]),
            .bus_clr_i  (bus_clr[i]),
            .flag_o     (flags_o[i])
        );
    end

endmodule

// File: rtl/irq_enable_reg.sv
// Enable mask register.
// A single write sets or clears the marked bits, and the write's top bit
// selects which. Assumes one-cycle write strobes.
module irq_enable_reg
    import irq_ctl_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 7,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] EN_ADDR = 4'hE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [NUM_SRC-1:0] enable_o
);

    en_dir_e            dir;
    logic [NUM_SRC-1:0] mark;

    // Split a write into its direction and its bit mask.
    always_comb begin
        dir  = en_dir_e'(wdata_i[DATA_W-1]);
        mark = wdata_i[NUM_SRC-1:0];
    end

    // Apply an enable write in the chosen direction.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable_o <= '0;
        else if (wr_i && (addr_i == EN_ADDR)) begin
            if (dir == EN_SET)
                enable_o <= enable_o | mark;
            else
                enable_o <= enable_o & ~mark;
        end
    end

endmodule

// File: rtl/irq_request_gen.sv
// Masks the flags and registers the request line.
// Also produces a one-cycle strobe whenever the registered request changes.
module irq_request_gen #(
    parameter int unsigned NUM_SRC = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] flags_i,
    input  logic [NUM_SRC-1:0] enable_i,
    output logic               req_o,
    output logic               changed_o
);

    logic req_next;

    // Any enabled, pending source requests service.
    always_comb req_next = |(flags_i & enable_i);

    // Register the request and flag its transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_o     <= 1'b0;
            changed_o <= 1'b0;
        end else begin
            req_o     <= req_next;
            changed_o <= (req_next != req_o);
        end
    end

endmodule

// File: rtl/irq_flag_ctrl.sv
// Top level of the interrupt flag and enable controller.
// Combines the flag bank, the enable register and the request generator,
// and multiplexes the read data. Reads have no side effects.
// Assumes NUM_SRC < DATA_W so the request fits in the top data bit.
module irq_flag_ctrl
    import irq_ctl_pkg::*;
#(
    parameter int unsigned NUM_SRC   = SRC_COUNT,
    parameter int unsigned DATA_W    = BUS_DATA_W,
    parameter int unsigned ADDR_W    = BUS_ADDR_W,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = ADDR_FLAGS,
    parameter logic [ADDR_W-1:0] EN_ADDR   = ADDR_ENABLE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_set,
    input  logic [NUM_SRC-1:0] src_clr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_req,
    output logic               irq_changed
);

    localparam int unsigned STATUS_BIT = DATA_W - 1;

    logic [NUM_SRC-1:0] flag_q;
    logic [NUM_SRC-1:0] en_q;

    irq_flag_bank #(
        .NUM_SRC   (NUM_SRC),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .FLAG_ADDR (FLAG_ADDR)
    ) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (src_set),
        .side_clr_i (src_clr),
        .addr_i     (bus_addr),
        .wr_i       (bus_wr),
        .wdata_i    (bus_wdata),
        .flags_o    (flag_q)
    );

    irq_enable_reg #(
        .NUM_SRC (NUM_SRC),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .EN_ADDR (EN_ADDR)
    ) u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (bus_addr),
        .wr_i     (bus_wr),
        .wdata_i  (bus_wdata),
        .enable_o (en_q)
    );

    irq_request_gen #(
        .NUM_SRC (NUM_SRC)
    ) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .flags_i   (flag_q),
        .enable_i  (en_q),
        .req_o     (irq_req),
        .changed_o (irq_changed)
    );

    // Read mux: flags with live request status, enables with top bit forced.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == FLAG_ADDR) begin
            bus_rdata[NUM_SRC-1:0] = flag_q;
            bus_rdata[STATUS_BIT]  = irq_req;
        end else if (bus_addr == EN_ADDR) begin
            bus_rdata[NUM_SRC-1:0] = en_q;
            bus_rdata[STATUS_BIT]  = 1'b1;
        end
    end

endmodule

// File: rtl/irq_flag_ctrl_chk.sv
// Property checker for the interrupt flag and enable controller.
// It is attached to every instance of the top by the bind below.
module irq_flag_ctrl_chk #(
    parameter int unsigned NUM_SRC = 7,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned ADDR_W  = 4,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 4'hD,
    parameter logic [ADDR_W-1:0] EN_ADDR   = 4'hE
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_set,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               irq_req,
    input logic               irq_changed,
    input logic [NUM_SRC-1:0] flag_q,
    input logic [NUM_SRC-1:0] en_q
);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_set != '0) |=> ((flag_q & $past(src_set)) == $past(src_set)));

    // R3
    bus_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == FLAG_ADDR) |=>
        ((flag_q & $past(bus_wdata[NUM_SRC-1:0] & ~src_set)) == '0));

    // R2
    req_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_req == $past(|(flag_q & en_q))));

    // R10
    strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_changed == (irq_req != $past(irq_req))));

    // R5
    flag_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == FLAG_ADDR) |-> (bus_rdata[DATA_W-1] == irq_req));

    // R6
    en_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == EN_ADDR) |-> bus_rdata[DATA_W-1]);

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (flag_q == '0 && en_q == '0 && !irq_req && !irq_changed));

endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(
    .NUM_SRC   (NUM_SRC),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .FLAG_ADDR (FLAG_ADDR),
    .EN_ADDR   (EN_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_set     (src_set),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .irq_req     (irq_req),
    .irq_changed (irq_changed),
    .flag_q      (flag_q),
    .en_q        (en_q)
);

// File: tb/irq_flag_ctrl_tb.sv
// Scoreboard bench: the driver queues expected reads, the monitor pops them.
module irq_flag_ctrl_tb;

    localparam logic [3:0] A_FLG = 4'hD;
    localparam logic [3:0] A_EN  = 4'hE;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] src_set = '0;
    logic [6:0] src_clr = '0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_req;
    logic       irq_changed;

    always #4 clk = ~clk;

    irq_flag_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_set     (src_set),
        .src_clr     (src_clr),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .irq_req     (irq_req),
        .irq_changed (irq_changed)
    );

    typedef struct {
        logic [7:0] data;
        logic       irq;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    logic chk_vld = 1'b0;
    logic [6:0] m_flag = '0;
    logic [6:0] m_en = '0;
    bit   done = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare read data and request against the queued item.
    always @(negedge clk) begin
        if (chk_vld && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(bus_rdata == e.data, e.tag, bus_rdata, e.data);
            check(irq_req == e.irq, {e.tag, " irq"}, irq_req, e.irq);
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic drive(input logic [6:0] s, input logic [6:0] c,
                         input logic w, input logic [3:0] a, input logic [7:0] d);
        step();
        src_set = s; src_clr = c; bus_wr = w; bus_addr = a; bus_wdata = d;
        step();
        src_set = '0; src_clr = '0; bus_wr = 1'b0;
    endtask

    task automatic do_write(input logic [3:0] a, input logic [7:0] d);
        drive('0, '0, 1'b1, a, d);
    endtask

    task automatic pulse_set(input logic [6:0] m);
        drive(m, '0, 1'b0, bus_addr, '0);
        m_flag |= m;
    endtask

    function automatic logic mirq();
        return |(m_flag & m_en);
    endfunction

    task automatic check_read(input logic [3:0] a, input string tag);
        exp_t e;
        step();
        bus_addr = a;
        if (a == A_FLG)     e.data = {mirq(), m_flag};
        else if (a == A_EN) e.data = {1'b1, m_en};
        else                e.data = 8'h00;
        e.irq = mirq();
        e.tag = tag;
        exp_q.push_back(e);
        chk_vld = 1'b1;
        @(negedge clk);
        #1;
        chk_vld = 1'b0;
    endtask

    // Strobe expected low, then high for one cycle, then low again.
    task automatic strobe_seq(input string tag);
        @(negedge clk);
        check(irq_changed == 1'b0, {tag, " pre"}, irq_changed, 0);
        @(negedge clk);
        check(irq_changed == 1'b1, {tag, " pulse"}, irq_changed, 1);
        @(negedge clk);
        check(irq_changed == 1'b0, {tag, " post"}, irq_changed, 0);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        // R7 reset state
        check_read(A_FLG, "R7 flags after reset");
        check_read(A_EN, "R6 R7 enable after reset");
        check(irq_changed == 1'b0, "R7 strobe after reset", irq_changed, 0);

        // R1 each source alone, masked so no request (R2)
        for (int i = 0; i < 7; i++) begin
            pulse_set(7'(1 << i));
            check_read(A_FLG, "R1 source bit");
            do_write(A_FLG, 8'h7F);
            m_flag = '0;
        end
        check_read(A_FLG, "R3 full acknowledge");

        // R4 set and clear enables
        do_write(A_EN, 8'h85); m_en = 7'h05;
        check_read(A_EN, "R4 set enables");
        do_write(A_EN, 8'h04); m_en = 7'h01;
        check_read(A_EN, "R4 clear enable");
        do_write(A_EN, 8'hC2); m_en = 7'h43;
        check_read(A_EN, "R4 set more enables");

        // R2 R10 rising request
        pulse_set(7'h02);
        strobe_seq("R10 rise");
        check_read(A_FLG, "R2 R5 request high");

        // R3 partial acknowledge
        pulse_set(7'h30);
        do_write(A_FLG, 8'h10); m_flag &= ~7'h10;
        check_read(A_FLG, "R3 partial ack");
        do_write(A_FLG, 8'h02); m_flag &= ~7'h02;
        check_read(A_FLG, "R2 disjoint enables no request");

        // R9 side-effect clears
        drive('0, 7'h20, 1'b0, A_FLG, '0); m_flag &= ~7'h20;
        check_read(A_FLG, "R9 side clear");
        pulse_set(7'h0C);
        drive('0, 7'h04, 1'b0, A_FLG, '0); m_flag &= ~7'h04;
        check_read(A_FLG, "R9 other flags kept");

        // R8 set versus clear collisions
        drive(7'h01, 7'h01, 1'b0, A_FLG, '0); m_flag |= 7'h01;
        check_read(A_FLG, "R8 set beats side clear");
        drive(7'h08, '0, 1'b1, A_FLG, 8'h08); m_flag |= 7'h08;
        check_read(A_FLG, "R8 set beats bus ack");

        // R11 other address
        do_write(4'h3, 8'hFF);
        check_read(4'h3, "R11 unmapped read");
        check_read(A_FLG, "R11 flags untouched");
        check_read(A_EN, "R11 enables untouched");

        // R10 falling request
        do_write(A_FLG, 8'h7F); m_flag = '0;
        strobe_seq("R10 fall");
        check_read(A_FLG, "R2 request low");

        // R7 mid-run reset
        pulse_set(7'h41);
        step(); rst_n = 1'b0;
        step(); step(); rst_n = 1'b1;
        m_flag = '0; m_en = '0;
        check_read(A_FLG, "R7 flags after mid reset");
        check_read(A_EN, "R7 enables after mid reset");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule